// File: doc/BRIEF.md
# Shared-Bus SRAM/Flash Access Controller

This block sits on the host side of a 32-bit memory module that holds an SRAM bank and a flash bank. The two banks share one address bus, one data bus and one output-enable line. Each bank has its own active-low chip select and four active-low byte-lane write enables. A system port issues one request at a time. Each request carries a bank bit, a 19-bit word address, 32 bits of write data, a 4-bit byte mask and a read/write flag. The controller runs one bus cycle on the selected bank and then pulses `done`. For a read, `rdData` holds the captured word from the `done` cycle onward.

All strobe widths are given as nanosecond parameters and converted to clock cycles by rounding up, with a floor of one cycle. One netlist can therefore meet a slow or a fast flash grade by changing only the parameters. Every bus cycle has four phases: an address setup phase, an active phase (output enable or write enable low), one hold cycle, and a bank-specific recovery phase in which every strobe is inactive. Multi-cycle flash command sequences are built by the requester from these single cycles.

With the default 5 ns clock the cycle counts are as follows. SRAM: setup 1, read strobe 5, write strobe 4, recovery 1. Flash: setup 1, read strobe 18, write strobe 9, recovery 4.

Top module: `memBusCtrl`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy` and `done` are 0, both chip selects and `memOeN` are 1, all eight write enables are 1 and `memDataOe` is 0.
- R2: `sramCsN` and `flashCsN` are never low in the same cycle.
- R3: An SRAM read (`reqBank`=0, `reqWrite`=0) holds `sramCsN` and `memOeN` low for exactly ceil(25 ns / clock) cycles with every write enable high, and returns the addressed word on `rdData`.
- R4: An SRAM write drives write-enable lane i (data bits 8i+7..8i) low for exactly ceil(20 ns / clock) cycles only when mask bit i is 1. Lanes whose mask bit is 0 stay high, so their bytes are unchanged. `memDataOe` is 1 whenever any write enable is low.
- R5: A flash read (`reqBank`=1, `reqWrite`=0) holds `flashCsN` and `memOeN` low for exactly ceil(90 ns / clock) cycles and returns the addressed word.
- R6: A flash write drives the masked flash lanes low for exactly ceil(45 ns / clock) cycles. Once a flash write enable rises, at least ceil(20 ns / clock) cycles pass before any flash write enable falls again.
- R7: `memDataOe` is never 1 while `memOeN` is 0. `memDataOe` never rises in the cycle right after a cycle with `memOeN` low.
- R8: `busy` stays 1 from the cycle after acceptance until `done`. A request presented while `busy` is 1 is dropped and leaves memory unchanged.
- R9: A write whose byte mask is 0 completes with a `done` pulse, asserts no write enable, and leaves the addressed word unchanged.
- R10: `done` is a single-cycle pulse. It appears setup + strobe + 1 + recovery cycles after the accepting clock edge: 8 for an SRAM read, 7 for an SRAM write, 24 for a flash read and 15 for a flash write at the default settings.
- R11: `memAddr` stays stable in every cycle in which a chip select is low and was already low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted only when `busy` is 0 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | 1 | 0 = SRAM bank, 1 = flash bank |
| reqAddr | input | 19 | Word address |
| reqWData | input | 32 | Write data |
| reqMask | input | 4 | Byte-lane mask for writes, bit i covers data bits 8i+7..8i |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Captured read data |
| memAddr | output | 19 | Shared address bus |
| memDataOut | output | 32 | Data driven toward the module |
| memDataOe | output | 1 | Drive enable for `memDataOut` |
| memDataIn | input | 32 | Data returned by the module |
| memOeN | output | 1 | Shared output enable, active low |
| sramCsN | output | 1 | SRAM chip select, active low |
| flashCsN | output | 1 | Flash chip select, active low |
| sramWeN | output | 4 | SRAM byte-lane write enables, active low |
| flashWeN | output | 4 | Flash byte-lane write enables, active low |

## Verification
On both banks, the bench sweeps all 16 byte masks over a known background word. A lane decoded wrongly, or a write enable on an unmasked lane, then shows up as a wrong byte on read-back. It then walks a single one through each of the 19 address bits, writing every address before reading any of them back. This separates a dropped or stuck address line, which makes two words alias, from a fault in the data path. The same addresses hold different data in the two banks, which shows a mixed-up bank select. Further sequences cover a request held high while busy, a zero-mask write, and a write issued right after a read. A behavioural model of both banks measures every strobe width, flash write-enable gap and latency against counts computed from the nanosecond figures.

// File: rtl/memBusPkg.sv
`timescale 1ns/1ps
package memBusPkg;

  // Strobes the control FSM hands to the datapath each cycle.
  typedef struct packed {
    logic load;      // latch request fields
    logic csSram;
    logic csFlash;
    logic oe;
    logic we;
    logic drive;     // enable write data onto the bus
    logic capture;   // sample read data
  } strobeT;

  // Round a time up to whole clock cycles, never below one.
  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/memBusFsm.sv
`timescale 1ns/1ps
module memBusFsm
  import memBusPkg::*;
#(
  parameter int CLK_NS        = 5,
  parameter int SRAM_SETUP_NS = 3,
  parameter int SRAM_RD_NS    = 25,
  parameter int SRAM_WP_NS    = 20,
  parameter int SRAM_REC_NS   = 0,
  parameter int FL_SETUP_NS   = 0,
  parameter int FL_RD_NS      = 90,
  parameter int FL_WP_NS      = 45,
  parameter int FL_REC_NS     = 20
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   reqBank,
  output logic   busy,
  output logic   done,
  output strobeT stb
);

  localparam int S_SET = nsToCycles(SRAM_SETUP_NS, CLK_NS);
  localparam int S_RD  = nsToCycles(SRAM_RD_NS, CLK_NS);
  localparam int S_WP  = nsToCycles(SRAM_WP_NS, CLK_NS);
  localparam int S_REC = nsToCycles(SRAM_REC_NS, CLK_NS);
  localparam int F_SET = nsToCycles(FL_SETUP_NS, CLK_NS);
  localparam int F_RD  = nsToCycles(FL_RD_NS, CLK_NS);
  localparam int F_WP  = nsToCycles(FL_WP_NS, CLK_NS);
  localparam int F_REC = nsToCycles(FL_REC_NS, CLK_NS);
  localparam int MAXC  = maxOf(maxOf(maxOf(S_SET, S_RD), maxOf(S_WP, S_REC)),
                               maxOf(maxOf(F_SET, F_RD), maxOf(F_WP, F_REC)));
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_HOLD, ST_RECOVER, ST_FINISH
  } stateT;

  stateT         state;
  logic [CW-1:0] cnt;
  logic          isWrite;
  logic          isFlash;
  logic          accept;
  logic          inCycle;
  logic [CW-1:0] setupLoad, actLoad, recLoad;

  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    setupLoad = reqBank ? CW'(F_SET - 1) : CW'(S_SET - 1);
    if (isFlash) begin
      actLoad = isWrite ? CW'(F_WP - 1) : CW'(F_RD - 1);
      recLoad = CW'(F_REC - 1);
    end else begin
      actLoad = isWrite ? CW'(S_WP - 1) : CW'(S_RD - 1);
      recLoad = CW'(S_REC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      isFlash <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          isWrite <= reqWrite;
          isFlash <= reqBank;
          cnt     <= setupLoad;
          state   <= ST_SETUP;
        end
        ST_SETUP: if (cnt == '0) begin
          cnt   <= actLoad;
          state <= ST_ACTIVE;
        end else cnt <= cnt - CW'(1);
        ST_ACTIVE: if (cnt == '0) state <= ST_HOLD;
                   else cnt <= cnt - CW'(1);
        ST_HOLD: begin
          cnt   <= recLoad;
          state <= ST_RECOVER;
        end
        ST_RECOVER: if (cnt == '0) state <= ST_FINISH;
                    else cnt <= cnt - CW'(1);
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign inCycle = (state == ST_SETUP) || (state == ST_ACTIVE) || (state == ST_HOLD);

  always_comb begin
    stb.load    = accept;
    stb.csSram  = inCycle && !isFlash;
    stb.csFlash = inCycle && isFlash;
    stb.oe      = (state == ST_ACTIVE) && !isWrite;
    stb.we      = (state == ST_ACTIVE) && isWrite;
    stb.drive   = inCycle && isWrite;
    stb.capture = (state == ST_ACTIVE) && !isWrite && (cnt == '0);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);  // R8
  AST_CAPTURE_READ: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (stb.oe && !stb.drive));  // R3

endmodule

// File: rtl/memBusDatapath.sv
`timescale 1ns/1ps
module memBusDatapath
  import memBusPkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 32,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [AW-1:0]    reqAddr,
  input  logic [DW-1:0]    reqWData,
  input  logic [LANES-1:0] reqMask,
  input  logic [DW-1:0]    memDataIn,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memDataOut,
  output logic             memDataOe,
  output logic             memOeN,
  output logic             sramCsN,
  output logic             flashCsN,
  output logic [LANES-1:0] sramWeN,
  output logic [LANES-1:0] flashWeN,
  output logic [DW-1:0]    rdData
);

  logic [AW-1:0]    addrReg;
  logic [DW-1:0]    dataReg;
  logic [LANES-1:0] maskReg;
  logic [DW-1:0]    rdReg;
  logic             csAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      maskReg <= '0;
      rdReg   <= '0;
    end else begin
      if (stb.load) begin
        addrReg <= reqAddr;
        dataReg <= reqWData;
        maskReg <= reqMask;
      end
      if (stb.capture) rdReg <= memDataIn;
    end
  end

  assign memAddr    = addrReg;
  assign memDataOut = dataReg;
  assign memDataOe  = stb.drive;
  assign memOeN     = !stb.oe;
  assign sramCsN    = !stb.csSram;
  assign flashCsN   = !stb.csFlash;
  assign rdData     = rdReg;
  assign csAny      = stb.csSram || stb.csFlash;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign sramWeN[l]  = !(stb.we && stb.csSram  && maskReg[l]);
    assign flashWeN[l] = !(stb.we && stb.csFlash && maskReg[l]);
  end

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (sramCsN || flashCsN));  // R2
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    !(memDataOe && !memOeN));  // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDataOe) |-> $past(memOeN));  // R7
  AST_WE_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ((~sramWeN | ~flashWeN) != '0) |-> memDataOe);  // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (csAny && $past(csAny)) |-> $stable(memAddr));  // R11

endmodule

// File: rtl/memBusCtrl.sv
`timescale 1ns/1ps
module memBusCtrl
  import memBusPkg::*;
#(
  parameter int CLK_NS        = 5,
  parameter int SRAM_SETUP_NS = 3,
  parameter int SRAM_RD_NS    = 25,
  parameter int SRAM_WP_NS    = 20,
  parameter int SRAM_REC_NS   = 0,
  parameter int FL_SETUP_NS   = 0,
  parameter int FL_RD_NS      = 90,
  parameter int FL_WP_NS      = 45,
  parameter int FL_REC_NS     = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqBank,
  input  logic [18:0] reqAddr,
  input  logic [31:0] reqWData,
  input  logic [3:0]  reqMask,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdData,
  output logic [18:0] memAddr,
  output logic [31:0] memDataOut,
  output logic        memDataOe,
  input  logic [31:0] memDataIn,
  output logic        memOeN,
  output logic        sramCsN,
  output logic        flashCsN,
  output logic [3:0]  sramWeN,
  output logic [3:0]  flashWeN
);

  strobeT stb;

  memBusFsm #(
    .CLK_NS(CLK_NS), .SRAM_SETUP_NS(SRAM_SETUP_NS), .SRAM_RD_NS(SRAM_RD_NS),
    .SRAM_WP_NS(SRAM_WP_NS), .SRAM_REC_NS(SRAM_REC_NS), .FL_SETUP_NS(FL_SETUP_NS),
    .FL_RD_NS(FL_RD_NS), .FL_WP_NS(FL_WP_NS), .FL_REC_NS(FL_REC_NS)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .busy(busy), .done(done), .stb(stb)
  );

  memBusDatapath #(.AW(19), .DW(32)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWData(reqWData),
    .reqMask(reqMask), .memDataIn(memDataIn), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memOeN(memOeN),
    .sramCsN(sramCsN), .flashCsN(flashCsN), .sramWeN(sramWeN),
    .flashWeN(flashWeN), .rdData(rdData)
  );

endmodule

// File: tb/memBusCtrl_bench.sv
`timescale 1ns/1ps
module memBusCtrl_bench;

  localparam int T      = 5;
  localparam int S_SET  = 1;
  localparam int S_RD   = (25 + T - 1) / T;
  localparam int S_WP   = (20 + T - 1) / T;
  localparam int S_REC  = 1;
  localparam int F_SET  = 1;
  localparam int F_RD   = (90 + T - 1) / T;
  localparam int F_WP   = (45 + T - 1) / T;
  localparam int F_REC  = (20 + T - 1) / T;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqBank = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [31:0] reqWData = '0;
  logic [3:0]  reqMask = '0;
  logic        busy, done, memDataOe, memOeN, sramCsN, flashCsN;
  logic [31:0] rdData, memDataOut;
  logic [31:0] memDataIn = 32'hDEADBEEF;
  logic [18:0] memAddr;
  logic [3:0]  sramWeN, flashWeN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  memBusCtrl u_memBusCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqAddr(reqAddr), .reqWData(reqWData), .reqMask(reqMask),
    .busy(busy), .done(done), .rdData(rdData), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn),
    .memOeN(memOeN), .sramCsN(sramCsN), .flashCsN(flashCsN),
    .sramWeN(sramWeN), .flashWeN(flashWeN)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model of both banks plus independent shadow copies.
  logic [31:0] sMem [bit [18:0]];
  logic [31:0] fMem [bit [18:0]];
  logic [31:0] sExp [bit [18:0]];
  logic [31:0] fExp [bit [18:0]];

  function automatic logic [31:0] laneMerge(input logic [31:0] old,
      input logic [31:0] d, input logic [3:0] m);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // Monitor state.
  int sWeRun = 0, fWeRun = 0, sOeRun = 0, fOeRun = 0, fWeGap = 1000;
  int overlapErr = 0, widthErr = 0, gapErr = 0, driveErr = 0, turnErr = 0;
  logic [3:0] opSWe = '0, opFWe = '0;
  logic prevOeLow = 1'b0, prevDrive = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      logic [31:0] w;
      if (!sramCsN && !flashCsN) overlapErr++;                       // R2
      if (memDataOe && !memOeN) driveErr++;                          // R7
      if (memDataOe && !prevDrive && prevOeLow) turnErr++;           // R7
      if ((~sramWeN | ~flashWeN) != 4'h0 && !memDataOe) driveErr++;  // R4
      prevOeLow = !memOeN;
      prevDrive = memDataOe;
      opSWe |= ~sramWeN;
      opFWe |= ~flashWeN;
      // model writes
      if (!sramCsN && sramWeN != 4'hF) begin
        w = sMem.exists(memAddr) ? sMem[memAddr] : 32'h0;
        sMem[memAddr] = laneMerge(w, memDataOut, ~sramWeN);
      end
      if (!flashCsN && flashWeN != 4'hF) begin
        w = fMem.exists(memAddr) ? fMem[memAddr] : 32'h0;
        fMem[memAddr] = laneMerge(w, memDataOut, ~flashWeN);
      end
      // model read data
      if (!memOeN && !sramCsN) memDataIn = sMem.exists(memAddr) ? sMem[memAddr] : 32'h0;
      else if (!memOeN && !flashCsN) memDataIn = fMem.exists(memAddr) ? fMem[memAddr] : 32'h0;
      else memDataIn = 32'hDEADBEEF;
      // widths: R4 SRAM WE, R6 flash WE and gap, R3/R5 OE
      if (sramWeN != 4'hF) sWeRun++;
      else if (sWeRun != 0) begin
        if (sWeRun != S_WP) begin widthErr++; $display("FAIL R4 sram we width actual=%0d expected=%0d", sWeRun, S_WP); end
        sWeRun = 0;
      end
      if (flashWeN != 4'hF) begin
        if (fWeRun == 0 && fWeGap < F_REC) begin
          gapErr++; $display("FAIL R6 flash we gap actual=%0d expected>=%0d", fWeGap, F_REC);
        end
        fWeRun++; fWeGap = 0;
      end else begin
        if (fWeRun != 0) begin
          if (fWeRun != F_WP) begin widthErr++; $display("FAIL R6 flash we width actual=%0d expected=%0d", fWeRun, F_WP); end
          fWeRun = 0;
        end
        if (fWeGap < 1000) fWeGap++;
      end
      if (!memOeN && !sramCsN) sOeRun++;
      else if (sOeRun != 0) begin
        if (sOeRun != S_RD) begin widthErr++; $display("FAIL R3 sram oe width actual=%0d expected=%0d", sOeRun, S_RD); end
        sOeRun = 0;
      end
      if (!memOeN && !flashCsN) fOeRun++;
      else if (fOeRun != 0) begin
        if (fOeRun != F_RD) begin widthErr++; $display("FAIL R5 flash oe width actual=%0d expected=%0d", fOeRun, F_RD); end
        fOeRun = 0;
      end
    end
  end

  // One request; optional second request held while busy (R8).
  task automatic doOp(input bit wr, input bit bank, input logic [18:0] a,
                      input logic [31:0] d, input logic [3:0] m, input bit inj,
                      input logic [18:0] injAddr, output logic [31:0] rd);
    int lat;
    int expLat;
    string tag;
    @(negedge clk);
    opSWe = '0; opFWe = '0;
    reqValid = 1'b1; reqWrite = wr; reqBank = bank; reqAddr = a;
    reqWData = d; reqMask = m;
    @(posedge clk);
    @(negedge clk);
    if (inj) begin
      reqWrite = 1'b1; reqAddr = injAddr; reqWData = ~d; reqMask = 4'hF;
      chk(busy === 1'b1, "R8 busy after accept", {31'b0, busy}, 32'h1);
    end else reqValid = 1'b0;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 1) reqValid = 1'b0;
      if (done === 1'b1 || lat > 100) break;
    end
    if (bank) expLat = F_SET + (wr ? F_WP : F_RD) + 1 + F_REC;
    else      expLat = S_SET + (wr ? S_WP : S_RD) + 1 + S_REC;
    tag = wr ? "R10 write latency" : "R10 read latency";
    chk(lat == expLat, tag, lat, expLat);
    rd = rdData;
    if (wr) begin
      if (bank) begin
        chk(opFWe == m && opSWe == 4'h0, "R6 R9 flash lanes", {24'b0, opSWe, opFWe}, {28'b0, m});
        fExp[a] = laneMerge(fExp.exists(a) ? fExp[a] : 32'h0, d, m);
      end else begin
        chk(opSWe == m && opFWe == 4'h0, "R4 R9 sram lanes", {24'b0, opFWe, opSWe}, {28'b0, m});
        sExp[a] = laneMerge(sExp.exists(a) ? sExp[a] : 32'h0, d, m);
      end
    end else begin
      chk(opSWe == 4'h0 && opFWe == 4'h0, "R3 R5 no we on read", {24'b0, opSWe, opFWe}, 32'h0);
    end
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R10 done single pulse", {31'b0, done}, 32'h0);
  endtask

  task automatic readChk(input bit bank, input logic [18:0] a, input string req);
    logic [31:0] rd;
    logic [31:0] e;
    doOp(1'b0, bank, a, 32'h0, 4'h0, 1'b0, 19'h0, rd);
    if (bank) e = fExp.exists(a) ? fExp[a] : 32'h0;
    else      e = sExp.exists(a) ? sExp[a] : 32'h0;
    chk(rd === e, req, rd, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state during reset
    chk({busy, done, sramCsN, flashCsN, memOeN, sramWeN, flashWeN, memDataOe}
        === {2'b00, 3'b111, 8'hFF, 1'b0}, "R1 reset outputs",
        {18'b0, busy, done, sramCsN, flashCsN, memOeN, sramWeN, flashWeN, memDataOe},
        {18'b0, 2'b00, 3'b111, 8'hFF, 1'b0});
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, done, sramCsN, flashCsN, memOeN, memDataOe} === 6'b001110,
        "R1 after release", {26'b0, busy, done, sramCsN, flashCsN, memOeN, memDataOe}, 32'h0E);

    // Mask sweep on both banks (R3 R4 R5 R6 R9)
    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 16; m++) begin
        logic [18:0] a;
        logic [31:0] d;
        a = 19'(m + 32);
        d = 32'h11111111 * (m + 1) ^ {13'b0, a} ^ (b != 0 ? 32'hF0F0F0F0 : 32'h0);
        doOp(1'b1, b[0], a, 32'hA5C3_5A3C, 4'hF, 1'b0, 19'h0, rd);
        doOp(1'b1, b[0], a, d, 4'(m), 1'b0, 19'h0, rd);
        readChk(b[0], a, b != 0 ? "R5 R6 R9 flash mask readback" : "R3 R4 R9 sram mask readback");
      end
    end

    // Walking address, both banks written before any read (R11 aliasing)
    for (int i = 0; i < 19; i++) begin
      doOp(1'b1, 1'b0, 19'(1 << i), 32'h5000_0000 + 32'(i * 7), 4'hF, 1'b0, 19'h0, rd);
      doOp(1'b1, 1'b1, 19'(1 << i), 32'hC000_0000 + 32'(i * 13), 4'hF, 1'b0, 19'h0, rd);
    end
    for (int i = 0; i < 19; i++) begin
      readChk(1'b0, 19'(1 << i), "R11 R3 sram walking address");
      readChk(1'b1, 19'(1 << i), "R11 R5 flash walking address");
    end

    // Request held while busy is dropped (R8)
    doOp(1'b1, 1'b0, 19'h7, 32'h1234_5678, 4'hF, 1'b0, 19'h0, rd);
    doOp(1'b1, 1'b0, 19'h100, 32'hCAFE_F00D, 4'hF, 1'b1, 19'h7, rd);
    readChk(1'b0, 19'h7, "R8 busy request ignored sram");
    doOp(1'b0, 1'b1, 19'h4, 32'h0, 4'h0, 1'b1, 19'h4, rd);
    readChk(1'b1, 19'h4, "R8 busy request ignored flash");

    // Zero-mask write leaves the word (R9)
    doOp(1'b1, 1'b1, 19'h100, 32'hFFFF_FFFF, 4'h0, 1'b0, 19'h0, rd);
    readChk(1'b1, 19'h100, "R9 zero mask flash");

    // Read then write back to back, flash writes back to back (R7 R6)
    readChk(1'b1, 19'h2, "R5 read before write");
    doOp(1'b1, 1'b1, 19'h2, 32'h0BAD_F00D, 4'h3, 1'b0, 19'h0, rd);
    doOp(1'b1, 1'b1, 19'h3, 32'h0BAD_F00D, 4'hC, 1'b0, 19'h0, rd);
    readChk(1'b1, 19'h2, "R6 back to back flash write");

    repeat (4) @(negedge clk);
    chk(overlapErr == 0, "R2 chip selects exclusive", overlapErr, 0);
    chk(driveErr == 0, "R7 R4 drive rules", driveErr, 0);
    chk(turnErr == 0, "R7 turnaround", turnErr, 0);
    chk(widthErr == 0, "R3 R4 R5 R6 strobe widths", widthErr, 0);
    chk(gapErr == 0, "R6 flash we recovery", gapErr, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule